// File: doc/BRIEF.md
# VGA raster timing generator

This block produces the horizontal and vertical synchronisation, pixel coordinates and blanking for a 640x480 raster. It runs from a single 50 MHz system clock: an internal enable that is high on every second clock edge sets a 25 MHz pixel rate, so the block needs no second clock domain. A colour stage downstream reads the column and row coordinates and the blank flag to choose each pixel's colour. It can use the two one-cycle-per-pixel flags, which mark the last visible column and the last visible row, to prepare the next line or frame.

The column counter covers the whole line, including retrace. Each full line advances the row counter by one. Sync pulses, blanking and the two flags are decoded from the counter values. The raster geometry is set by parameters whose defaults give 640x480. The active-low reset clears the block at once, and its release passes through two synchroniser flops before the block leaves reset.

Top module: `vga_raster_gen`

## Requirements
- R1: The coordinates advance on every second rising clock edge. After `rst_n` rises, the first change (column 0 to 1) happens on the fourth rising edge, and later changes happen on the sixth, the eighth and every following even edge.
- R2: On an edge where the internal enable is low, `col` and `row` keep their values.
- R3: `col` counts up by one from 0 to 799 and then returns to 0.
- R4: `hsync_n` is 0 for columns 656 to 751 inclusive and 1 for every other column.
- R5: `last_col` is 1 exactly when `col` is 639.
- R6: `row` goes up by one on each step where `col` wraps from 799 to 0. It counts 0 to 524 and returns to 0 on the same step as that column wrap.
- R7: `vsync_n` is 0 for rows 490 and 491 and 1 for every other row.
- R8: `last_row` is 1 for every column of row 479 and 0 for every other row.
- R9: `blank` is 1 exactly when `col` > 639 or `row` > 479.
- R10: While `rst_n` is 0, and without waiting for a clock edge, `col` = 0, `row` = 0, `hsync_n` = 1, `vsync_n` = 1, `blank` = 0, `last_col` = 0 and `last_row` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| col | output | 10 | Current column, 0 to 799 |
| row | output | 10 | Current row, 0 to 524 |
| blank | output | 1 | Pixel lies outside the visible area |
| last_col | output | 1 | Current column is the last visible one |
| last_row | output | 1 | Current row is the last visible one |

## Verification
The bench targets the phase edges: columns 639, 640, 655, 656, 751, 752 and 799, and the line wrap. An off-by-one decode at any of these moves the sync pulse or blanking by one pixel and a monitor would lose lock. A second instance with a small raster is run across many frames, so every row boundary is checked: the vertical pulse, the last-row flag, and the row wrapping on the same step as the column. A design that wraps the row one step late shows a short first line. The bench also asserts reset in the middle of a cycle and then checks the restart latency, which catches a synchronous reset or an enable that starts in the wrong phase.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

  localparam int unsigned DEF_COORD_W = 10;
  localparam int unsigned DEF_H_VIS   = 640;
  localparam int unsigned DEF_H_FRONT = 16;
  localparam int unsigned DEF_H_PULSE = 96;
  localparam int unsigned DEF_H_BACK  = 48;
  localparam int unsigned DEF_V_VIS   = 480;
  localparam int unsigned DEF_V_FRONT = 10;
  localparam int unsigned DEF_V_PULSE = 2;
  localparam int unsigned DEF_V_BACK  = 33;

  // Segments of one axis in scan order
  typedef enum logic [1:0] {
    SEG_SHOW  = 2'd0,
    SEG_FRONT = 2'd1,
    SEG_PULSE = 2'd2,
    SEG_BACK  = 2'd3
  } seg_e;

  function automatic seg_e seg_of(input int unsigned pos,
                                  input int unsigned vis,
                                  input int unsigned front,
                                  input int unsigned pulse);
    seg_e s;
    if (pos < vis)                      s = SEG_SHOW;
    else if (pos < vis + front)         s = SEG_FRONT;
    else if (pos < vis + front + pulse) s = SEG_PULSE;
    else                                s = SEG_BACK;
    return s;
  endfunction

endpackage

// File: rtl/vga_rst_sync.sv
module vga_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/vga_pix_enable.sv
module vga_pix_enable (
  input  logic clk,
  input  logic rst_n,
  output logic pix_en
);

  logic en_q;
  logic en_d;

  always_comb begin
    en_d = ~en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign pix_en = en_q;

endmodule

// File: rtl/vga_axis.sv
module vga_axis
  import vga_raster_pkg::*;
#(
  parameter int unsigned W     = 10,
  parameter int unsigned VIS   = 640,
  parameter int unsigned FRONT = 16,
  parameter int unsigned PULSE = 96,
  parameter int unsigned BACK  = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] pos,
  output logic         at_end,
  output logic         visible,
  output logic         pulse_n,
  output logic         on_last
);

  localparam int unsigned  TOTAL    = VIS + FRONT + PULSE + BACK;
  localparam logic [W-1:0] END_POS  = W'(TOTAL - 1);
  localparam logic [W-1:0] LAST_VIS = W'(VIS - 1);

  logic [W-1:0] pos_q;
  logic [W-1:0] pos_d;
  seg_e         seg;

  always_comb begin
    pos_d = pos_q;
    if (step) begin
      if (pos_q == END_POS) pos_d = '0;
      else                  pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  always_comb begin
    seg     = seg_of(int'(pos_q), VIS, FRONT, PULSE);
    visible = (seg == SEG_SHOW);
    pulse_n = (seg != SEG_PULSE);
    on_last = (pos_q == LAST_VIS);
    at_end  = (pos_q == END_POS);
  end

  assign pos = pos_q;

endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
  import vga_raster_pkg::*;
#(
  parameter int unsigned COORD_W = DEF_COORD_W,
  parameter int unsigned H_VIS   = DEF_H_VIS,
  parameter int unsigned H_FRONT = DEF_H_FRONT,
  parameter int unsigned H_PULSE = DEF_H_PULSE,
  parameter int unsigned H_BACK  = DEF_H_BACK,
  parameter int unsigned V_VIS   = DEF_V_VIS,
  parameter int unsigned V_FRONT = DEF_V_FRONT,
  parameter int unsigned V_PULSE = DEF_V_PULSE,
  parameter int unsigned V_BACK  = DEF_V_BACK
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               hsync_n,
  output logic               vsync_n,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output logic               blank,
  output logic               last_col,
  output logic               last_row
);

  logic srst_n;
  logic pix_en;
  logic h_end;
  logic h_vis;
  logic v_step;
  logic v_end;
  logic v_vis;

  vga_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  vga_pix_enable i_pix_enable (
    .clk    (clk),
    .rst_n  (srst_n),
    .pix_en (pix_en)
  );

  vga_axis #(
    .W     (COORD_W),
    .VIS   (H_VIS),
    .FRONT (H_FRONT),
    .PULSE (H_PULSE),
    .BACK  (H_BACK)
  ) i_h_axis (
    .clk     (clk),
    .rst_n   (srst_n),
    .step    (pix_en),
    .pos     (col),
    .at_end  (h_end),
    .visible (h_vis),
    .pulse_n (hsync_n),
    .on_last (last_col)
  );

  // The row moves only on the enabled step that ends a line
  always_comb begin
    v_step = pix_en & h_end;
  end

  vga_axis #(
    .W     (COORD_W),
    .VIS   (V_VIS),
    .FRONT (V_FRONT),
    .PULSE (V_PULSE),
    .BACK  (V_BACK)
  ) i_v_axis (
    .clk     (clk),
    .rst_n   (srst_n),
    .step    (v_step),
    .pos     (row),
    .at_end  (v_end),
    .visible (v_vis),
    .pulse_n (vsync_n),
    .on_last (last_row)
  );

  always_comb begin
    blank = ~(h_vis & v_vis);
  end

endmodule

// File: rtl/vga_raster_chk.sv
module vga_raster_chk #(
  parameter int unsigned COORD_W = 10,
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned V_TOTAL = 525
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srst_n,
  input logic               pix_en,
  input logic [COORD_W-1:0] col,
  input logic [COORD_W-1:0] row,
  input logic               hsync_n,
  input logic               vsync_n,
  input logic               blank,
  input logic               last_col
);

  localparam logic [COORD_W-1:0] H_END = COORD_W'(H_TOTAL - 1);
  localparam logic [COORD_W-1:0] V_END = COORD_W'(V_TOTAL - 1);

  p_en_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

  p_en_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_n && !pix_en) |=> pix_en);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(col) && $stable(row)));

  p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && col != H_END) |=> (col == $past(col) + 1'b1));

  p_col_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && col == H_END) |=> (col == '0));

  p_hs_in_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> blank);

  p_lastcol_then_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && last_col) |=> blank);

  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && col == H_END && row != V_END) |=> (row == $past(row) + 1'b1));

  p_row_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && col == H_END && row == V_END) |=> (row == '0 && col == '0));

  p_row_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (col != H_END) |=> $stable(row));

  p_vs_in_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> blank);

endmodule

bind vga_raster_gen vga_raster_chk #(
  .COORD_W (COORD_W),
  .H_TOTAL (H_VIS + H_FRONT + H_PULSE + H_BACK),
  .V_TOTAL (V_VIS + V_FRONT + V_PULSE + V_BACK)
) i_raster_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .srst_n   (srst_n),
  .pix_en   (pix_en),
  .col      (col),
  .row      (row),
  .hsync_n  (hsync_n),
  .vsync_n  (vsync_n),
  .blank    (blank),
  .last_col (last_col)
);

// File: tb/test_vga_raster_gen.sv
module test_vga_raster_gen;

  // Full-size geometry (defaults)
  localparam int HV = 640, HF = 16, HS = 96, HT = 800;
  localparam int VV = 480, VF = 10, VS = 2,  VT = 525;
  // Reduced geometry for whole-frame coverage
  localparam int SHV = 8, SHF = 2, SHS = 3, SHB = 2, SHT = 15;
  localparam int SVV = 6, SVF = 1, SVS = 2, SVB = 2, SVT = 11;

  // step, col, row, hsync_n, vsync_n, blank, last_col, last_row
  localparam int NVEC = 11;
  localparam int VEC [NVEC][8] = '{
    '{   0,   0, 0, 1, 1, 0, 0, 0},
    '{ 639, 639, 0, 1, 1, 0, 1, 0},
    '{ 640, 640, 0, 1, 1, 1, 0, 0},
    '{ 655, 655, 0, 1, 1, 1, 0, 0},
    '{ 656, 656, 0, 0, 1, 1, 0, 0},
    '{ 751, 751, 0, 0, 1, 1, 0, 0},
    '{ 752, 752, 0, 1, 1, 1, 0, 0},
    '{ 799, 799, 0, 1, 1, 1, 0, 0},
    '{ 800,   0, 1, 1, 1, 0, 0, 0},
    '{1439, 639, 1, 1, 1, 0, 1, 0},
    '{2400,   0, 3, 1, 1, 0, 0, 0}
  };

  logic clk;
  logic rst_n;
  logic d_hs, d_vs, d_blank, d_lc, d_lr;
  logic [9:0] d_col, d_row;
  logic s_hs, s_vs, s_blank, s_lc, s_lr;
  logic [9:0] s_col, s_row;

  int total;
  int bad;
  int edge_no;
  int prev_col;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  vga_raster_gen i_vga_raster_gen (
    .clk (clk), .rst_n (rst_n),
    .hsync_n (d_hs), .vsync_n (d_vs), .col (d_col), .row (d_row),
    .blank (d_blank), .last_col (d_lc), .last_row (d_lr)
  );

  vga_raster_gen #(
    .H_VIS (SHV), .H_FRONT (SHF), .H_PULSE (SHS), .H_BACK (SHB),
    .V_VIS (SVV), .V_FRONT (SVF), .V_PULSE (SVS), .V_BACK (SVB)
  ) i_small (
    .clk (clk), .rst_n (rst_n),
    .hsync_n (s_hs), .vsync_n (s_vs), .col (s_col), .row (s_row),
    .blank (s_blank), .last_col (s_lc), .last_row (s_lr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int steps_of(input int e);
    return (e < 2) ? 0 : (e - 2) / 2;
  endfunction

  // Expected outputs of a raster from its column/row and geometry
  task automatic chk_raster(input string who, input int steps,
                            input int hv, input int hf, input int hs, input int ht,
                            input int vv, input int vf, input int vs, input int vt,
                            input int c, input int r, input logic hsn, input logic vsn,
                            input logic bl, input logic lc, input logic lr);
    int h = steps % ht;
    int v = (steps / ht) % vt;
    chk("R3", {who, " col"}, c, h);
    chk("R6", {who, " row"}, r, v);
    chk("R4", {who, " hsync_n"}, int'(hsn), (h >= hv + hf && h < hv + hf + hs) ? 0 : 1);
    chk("R7", {who, " vsync_n"}, int'(vsn), (v >= vv + vf && v < vv + vf + vs) ? 0 : 1);
    chk("R9", {who, " blank"}, int'(bl), (h >= hv || v >= vv) ? 1 : 0);
    chk("R5", {who, " last_col"}, int'(lc), (h == hv - 1) ? 1 : 0);
    chk("R8", {who, " last_row"}, int'(lr), (v == vv - 1) ? 1 : 0);
  endtask

  task automatic tick();
    int st;
    @(posedge clk);
    @(negedge clk);
    edge_no++;
    st = steps_of(edge_no);
    if (edge_no == 3) chk("R1", "col before first step", int'(d_col), 0);
    if (edge_no == 4) chk("R1", "col after first step", int'(d_col), 1);
    if (st == steps_of(edge_no - 1)) chk("R2", "col held", int'(d_col), prev_col);
    prev_col = int'(d_col);
    chk_raster("small", st, SHV, SHF, SHS, SHT, SVV, SVF, SVS, SVT,
               int'(s_col), int'(s_row), s_hs, s_vs, s_blank, s_lc, s_lr);
    chk_raster("full", st, HV, HF, HS, HT, VV, VF, VS, VT,
               int'(d_col), int'(d_row), d_hs, d_vs, d_blank, d_lc, d_lr);
  endtask

  task automatic chk_reset_state(input string when);
    chk("R10", {when, " col"},      int'(d_col), 0);
    chk("R10", {when, " row"},      int'(d_row), 0);
    chk("R10", {when, " hsync_n"},  int'(d_hs), 1);
    chk("R10", {when, " vsync_n"},  int'(d_vs), 1);
    chk("R10", {when, " blank"},    int'(d_blank), 0);
    chk("R10", {when, " last_col"}, int'(d_lc), 0);
    chk("R10", {when, " last_row"}, int'(d_lr), 0);
    chk("R10", {when, " small col"}, int'(s_col), 0);
    chk("R10", {when, " small row"}, int'(s_row), 0);
  endtask

  initial begin
    total = 0;
    bad = 0;
    edge_no = 0;
    prev_col = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_reset_state("power-up");
    rst_n = 1'b1;

    // Vector walk over the full-size raster, with per-edge model checks
    for (int i = 0; i < NVEC; i++) begin
      while (steps_of(edge_no) < VEC[i][0]) tick();
      chk("R3", "vec col",      int'(d_col),   VEC[i][1]);
      chk("R6", "vec row",      int'(d_row),   VEC[i][2]);
      chk("R4", "vec hsync_n",  int'(d_hs),    VEC[i][3]);
      chk("R7", "vec vsync_n",  int'(d_vs),    VEC[i][4]);
      chk("R9", "vec blank",    int'(d_blank), VEC[i][5]);
      chk("R5", "vec last_col", int'(d_lc),    VEC[i][6]);
      chk("R8", "vec last_row", int'(d_lr),    VEC[i][7]);
    end

    // Asynchronous reset in the middle of a cycle
    @(posedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk_reset_state("async");
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_reset_state("held");
    rst_n = 1'b1;
    edge_no = 0;
    prev_col = 0;
    repeat (400) tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule